// File: doc/BRIEF.md
# Consecutive-Breach Boost Frequency Controller

This block keeps the boost frequency of one activity-monitor channel. A monitor raises a strobe when the channel has stayed above its upper watermark for several periods, or below its lower watermark. On an upper strobe the boost grows by a percentage and a fixed step, and it is capped at a maximum frequency. On a lower strobe it shrinks by a percentage and drops to zero once it falls under half a step. Each direction's consecutive-breach interrupt enable is re-armed or disarmed as part of the same update.

After the boost update the block forms a target frequency. The average activity count is divided by the sampling period in milliseconds. That rate is scaled by a sustain coefficient equal to 10000 divided by the up threshold, divided by 100, and the new boost is added. All divisions share one serial divider, so an update takes a few hundred cycles. A one-cycle `done` pulse marks the cycle in which the boost, target and enable outputs change together.

Strobes that arrive while an update runs are remembered and served afterwards. A `start` pulse puts the channel back into its initial state at any time.

Top module: `boostGovernor`

## Requirements
- R1: On an upper event the new boost is min(B×U/100 + 16000, M). B is the old boost, U is `upCoeff`, M is `maxFreq`, division truncates, and the cap applies when B×U/100 + 16000 ≥ M.
- R2: An upper event always sets `belowEn`. It clears `aboveEn` when the cap of R1 is applied and otherwise leaves `aboveEn` unchanged. At least one of the two enables is always set.
- R3: On a lower event the new boost is B×D/100, where D is `downCoeff`. If that value is below 8000 the boost becomes 0.
- R4: A lower event always sets `aboveEn`. It clears `belowEn` when the snap to zero of R3 applies and otherwise leaves `belowEn` unchanged.
- R5: If an upper and a lower event are both pending when an update begins, only the upper one is applied, and both are consumed.
- R6: Every percentage product divided by 100 saturates at 2^32−1 before any further use.
- R7: `target` (33 bits) = sat((A/P) × (10000/T) / 100) + new boost. A is `avgCount`, P is `periodMs`, T is `upThresh`, and every division truncates.
- R8: Reset or a `start` pulse sets boost 0, target 0, `aboveEn` 1 and `belowEn` 0 in the next cycle. It also drops any pending event or update in progress; no `done` follows.
- R9: `done` is a one-cycle pulse. The boost, target and enable outputs change only in the cycle `done` is high.
- R10: An event strobe that arrives during an update is kept and served after it. Several strobes of one kind during one update merge into a single event.
- R11: With no event pending the outputs hold and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart pulse, returns the channel to its initial state |
| upEvt | input | 1 | Consecutive-upper breach strobe |
| lowEvt | input | 1 | Consecutive-lower breach strobe |
| avgCount | input | 32 | Average activity count of the last period |
| periodMs | input | 9 | Sampling period length, nonzero |
| maxFreq | input | 32 | Boost ceiling |
| upCoeff | input | 16 | Upper scaling percentage |
| downCoeff | input | 16 | Lower scaling percentage |
| upThresh | input | 8 | Up threshold percentage, nonzero |
| boost | output | 32 | Current boost value |
| target | output | 33 | Target frequency |
| aboveEn | output | 1 | Consecutive-upper interrupt enable |
| belowEn | output | 1 | Consecutive-lower interrupt enable |
| done | output | 1 | Outputs-updated pulse |

## Verification
Two kinds of overlap are provoked. The first is the arrival of new breach strobes while an update is still dividing. The second is an upper and a lower strobe in the same cycle. The bench pulses both strobes together and expects exactly one upper result followed by a quiet window. It also fires a lower strobe, twice, during an upper update and expects the upper result, then a single lower result, then silence. A restart issued in the middle of an update must give the initial outputs at once and never produce a late `done`.

// File: rtl/bcPkg.sv
package bcPkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;     // restart: return to initial state
    logic ldEvt;     // start boost x coeff / 100
    logic ldAvg;     // start avg / period
    logic ldCoef;    // start 10000 / threshold, capture avg rate
    logic ldScale;   // start rate x coef / 100
    logic applyEvt;  // commit boost and enables from quotient
    logic isUp;      // event direction for ldEvt / applyEvt
    logic publish;   // copy working state to outputs, form target
  } bcCtrlT;
endpackage

// File: rtl/bcSeqDiv.sv
module bcSeqDiv #(
  parameter int NW = 48,
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          load,
  input  logic [NW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic [NW-1:0] quotient,
  output logic          done
);
  localparam int CNTW = $clog2(NW);

  logic [NW-1:0]   quoR;
  logic [VW-1:0]   divR;
  logic [VW:0]     remR;
  logic [CNTW-1:0] cntR;
  logic            runR;
  logic [VW:0]     shifted;
  logic            fits;

  assign shifted  = {remR[VW-1:0], quoR[NW-1]};
  assign fits     = shifted >= {1'b0, divR};
  assign quotient = quoR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoR <= '0; divR <= '0; remR <= '0; cntR <= '0; runR <= 1'b0; done <= 1'b0;
    end else if (clear) begin
      quoR <= '0; divR <= '0; remR <= '0; cntR <= '0; runR <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        quoR <= dividend;
        divR <= divisor;
        remR <= '0;
        cntR <= '0;
        runR <= 1'b1;
      end else if (runR) begin
        remR <= fits ? (shifted - {1'b0, divR}) : shifted;
        quoR <= {quoR[NW-2:0], fits};
        if (cntR == CNTW'(NW - 1)) begin
          runR <= 1'b0;
          done <= 1'b1;
        end else begin
          cntR <= cntR + 1'b1;
        end
      end
    end
  end

  AST_DIV_NO_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    load |-> !runR); // R9
endmodule

// File: rtl/bcControl.sv
module bcControl
  import bcPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   upEvt,
  input  logic   lowEvt,
  input  logic   divDone,
  output bcCtrlT ctrl,
  output logic   done
);
  typedef enum logic [2:0] {ST_IDLE, ST_EVT, ST_AVG, ST_COEF, ST_SCALE} bcStateT;

  bcStateT st, stNxt;
  logic    pendUp, pendLow, upSel, consume;

  always_comb begin
    ctrl      = '0;
    ctrl.isUp = upSel;
    consume   = 1'b0;
    stNxt     = st;
    unique case (st)
      ST_IDLE: if (pendUp || pendLow) begin
        ctrl.ldEvt = 1'b1;
        ctrl.isUp  = pendUp;
        consume    = 1'b1;
        stNxt      = ST_EVT;
      end
      ST_EVT: if (divDone) begin
        ctrl.applyEvt = 1'b1;
        ctrl.ldAvg    = 1'b1;
        stNxt         = ST_AVG;
      end
      ST_AVG: if (divDone) begin
        ctrl.ldCoef = 1'b1;
        stNxt       = ST_COEF;
      end
      ST_COEF: if (divDone) begin
        ctrl.ldScale = 1'b1;
        stNxt        = ST_SCALE;
      end
      ST_SCALE: if (divDone) begin
        ctrl.publish = 1'b1;
        stNxt        = ST_IDLE;
      end
      default: stNxt = ST_IDLE;
    endcase
    if (start) begin
      ctrl       = '0;
      ctrl.clear = 1'b1;
      consume    = 1'b0;
      stNxt      = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE; pendUp <= 1'b0; pendLow <= 1'b0; upSel <= 1'b0; done <= 1'b0;
    end else if (start) begin
      st <= ST_IDLE; pendUp <= 1'b0; pendLow <= 1'b0; upSel <= 1'b0; done <= 1'b0;
    end else begin
      st      <= stNxt;
      pendUp  <= (pendUp  & ~consume) | upEvt;
      pendLow <= (pendLow & ~consume) | lowEvt;
      if (consume) upSel <= pendUp;
      done    <= ctrl.publish;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.ldEvt, ctrl.ldAvg, ctrl.ldCoef, ctrl.ldScale})); // R9
  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (lowEvt && !start) |=> pendLow); // R10
  AST_UP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && pendUp && pendLow && !start) |=> upSel); // R5
endmodule

// File: rtl/bcDatapath.sv
module bcDatapath
  import bcPkg::*;
#(
  parameter int DW      = 32,
  parameter int CW      = 16,
  parameter int PW      = 9,
  parameter int TW      = 8,
  parameter int STEP    = 16000,
  parameter int SUSTAIN = 10000
) (
  input  logic          clk,
  input  logic          rstN,
  input  bcCtrlT        ctrl,
  input  logic [DW-1:0] avgCount,
  input  logic [PW-1:0] periodMs,
  input  logic [DW-1:0] maxFreq,
  input  logic [CW-1:0] upCoeff,
  input  logic [CW-1:0] downCoeff,
  input  logic [TW-1:0] upThresh,
  output logic [DW-1:0] boostOut,
  output logic [DW:0]   targetOut,
  output logic          aboveEnOut,
  output logic          belowEnOut,
  output logic          divDone
);
  localparam int NW   = DW + CW;
  localparam int HALF = STEP / 2;

  logic [DW-1:0] workBoost, t1R;
  logic          workAbove, workBelow;
  logic [NW-1:0] divDividend, divQ;
  logic [CW-1:0] divDivisor, coeffSel;
  logic          divLoad;
  logic [DW-1:0] satQ;
  logic [DW:0]   upSum;

  assign coeffSel = ctrl.isUp ? upCoeff : downCoeff;
  assign divLoad  = ctrl.ldEvt | ctrl.ldAvg | ctrl.ldCoef | ctrl.ldScale;
  assign satQ     = (|divQ[NW-1:DW]) ? '1 : divQ[DW-1:0];
  assign upSum    = {1'b0, satQ} + (DW+1)'(STEP);

  always_comb begin
    divDividend = '0;
    divDivisor  = '0;
    if (ctrl.ldEvt) begin
      divDividend = NW'(workBoost) * NW'(coeffSel);
      divDivisor  = CW'(100);
    end else if (ctrl.ldAvg) begin
      divDividend = NW'(avgCount);
      divDivisor  = CW'(periodMs);
    end else if (ctrl.ldCoef) begin
      divDividend = NW'(SUSTAIN);
      divDivisor  = CW'(upThresh);
    end else if (ctrl.ldScale) begin
      divDividend = NW'(t1R) * NW'(divQ[CW-1:0]);
      divDivisor  = CW'(100);
    end
  end

  bcSeqDiv #(.NW(NW), .VW(CW)) uDiv (
    .clk(clk), .rstN(rstN), .clear(ctrl.clear), .load(divLoad),
    .dividend(divDividend), .divisor(divDivisor),
    .quotient(divQ), .done(divDone)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workBoost <= '0; workAbove <= 1'b1; workBelow <= 1'b0; t1R <= '0;
      boostOut <= '0; targetOut <= '0; aboveEnOut <= 1'b1; belowEnOut <= 1'b0;
    end else if (ctrl.clear) begin
      workBoost <= '0; workAbove <= 1'b1; workBelow <= 1'b0; t1R <= '0;
      boostOut <= '0; targetOut <= '0; aboveEnOut <= 1'b1; belowEnOut <= 1'b0;
    end else begin
      if (ctrl.applyEvt) begin
        if (ctrl.isUp) begin
          if (upSum >= {1'b0, maxFreq}) begin
            workBoost <= maxFreq;
            workAbove <= 1'b0;
          end else begin
            workBoost <= upSum[DW-1:0];
          end
          workBelow <= 1'b1;
        end else begin
          if (satQ < DW'(HALF)) begin
            workBoost <= '0;
            workBelow <= 1'b0;
          end else begin
            workBoost <= satQ;
          end
          workAbove <= 1'b1;
        end
      end
      if (ctrl.ldCoef) t1R <= divQ[DW-1:0];
      if (ctrl.publish) begin
        boostOut   <= workBoost;
        aboveEnOut <= workAbove;
        belowEnOut <= workBelow;
        targetOut  <= {1'b0, satQ} + {1'b0, workBoost};
      end
    end
  end

  AST_BOOST_CAPPED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.applyEvt && ctrl.isUp && !ctrl.clear) |=> workBoost <= maxFreq); // R1
  AST_SNAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.applyEvt && !ctrl.isUp && !ctrl.clear) |=> (workBoost == '0 || workBoost >= DW'(HALF))); // R3
  AST_ONE_DIR_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    aboveEnOut || belowEnOut); // R2
  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clear |=> (boostOut == '0 && targetOut == '0 && aboveEnOut && !belowEnOut)); // R8
  AST_OUT_ONLY_ON_PUBLISH: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.publish && !ctrl.clear) |=> $stable(boostOut) && $stable(targetOut)); // R9
endmodule

// File: rtl/boostGovernor.sv
module boostGovernor
  import bcPkg::*;
#(
  parameter int DW      = 32,
  parameter int CW      = 16,
  parameter int PW      = 9,
  parameter int TW      = 8,
  parameter int STEP    = 16000,
  parameter int SUSTAIN = 10000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          upEvt,
  input  logic          lowEvt,
  input  logic [DW-1:0] avgCount,
  input  logic [PW-1:0] periodMs,
  input  logic [DW-1:0] maxFreq,
  input  logic [CW-1:0] upCoeff,
  input  logic [CW-1:0] downCoeff,
  input  logic [TW-1:0] upThresh,
  output logic [DW-1:0] boost,
  output logic [DW:0]   target,
  output logic          aboveEn,
  output logic          belowEn,
  output logic          done
);
  bcCtrlT ctrl;
  logic   divDone;

  bcControl uCtl (
    .clk(clk), .rstN(rstN), .start(start), .upEvt(upEvt), .lowEvt(lowEvt),
    .divDone(divDone), .ctrl(ctrl), .done(done)
  );

  bcDatapath #(.DW(DW), .CW(CW), .PW(PW), .TW(TW), .STEP(STEP), .SUSTAIN(SUSTAIN)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .avgCount(avgCount), .periodMs(periodMs), .maxFreq(maxFreq),
    .upCoeff(upCoeff), .downCoeff(downCoeff), .upThresh(upThresh),
    .boostOut(boost), .targetOut(target), .aboveEnOut(aboveEn), .belowEnOut(belowEn),
    .divDone(divDone)
  );
endmodule

// File: tb/boostGovernor_test.sv
module boostGovernor_test;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned SAT = 64'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, upEvt = 1'b0, lowEvt = 1'b0;
  logic [31:0] avgCount = 32'd0, maxFreq = 32'd0;
  logic [8:0]  periodMs = 9'd12;
  logic [15:0] upCoeff = 16'd200, downCoeff = 16'd50;
  logic [7:0]  upThresh = 8'd60;
  logic [31:0] boost;
  logic [32:0] target;
  logic        aboveEn, belowEn, done;

  int compared = 0, mismatched = 0;
  longint unsigned mBoost = 0, mTarget = 0;
  bit mAbove = 1'b1, mBelow = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boostGovernor uut (
    .clk(clk), .rstN(rstN), .start(start), .upEvt(upEvt), .lowEvt(lowEvt),
    .avgCount(avgCount), .periodMs(periodMs), .maxFreq(maxFreq),
    .upCoeff(upCoeff), .downCoeff(downCoeff), .upThresh(upThresh),
    .boost(boost), .target(target), .aboveEn(aboveEn), .belowEn(belowEn), .done(done)
  );

  task automatic chk(bit ok, string req, longint unsigned act, longint unsigned exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void modelEvt(bit up);
    longint unsigned p, s, t1, c, sc;
    if (up) begin
      p = mBoost * 64'(upCoeff) / 100;
      if (p > SAT) p = SAT;
      s = p + 16000;
      if (s >= 64'(maxFreq)) begin mBoost = 64'(maxFreq); mAbove = 1'b0; end
      else mBoost = s;
      mBelow = 1'b1;
    end else begin
      p = mBoost * 64'(downCoeff) / 100;
      if (p > SAT) p = SAT;
      if (p < 8000) begin mBoost = 0; mBelow = 1'b0; end
      else mBoost = p;
      mAbove = 1'b1;
    end
    t1 = 64'(avgCount) / 64'(periodMs);
    c  = 10000 / 64'(upThresh);
    sc = t1 * c / 100;
    if (sc > SAT) sc = SAT;
    mTarget = sc + mBoost;
  endfunction

  task automatic checkOut(string req);
    chk(64'(boost) == mBoost, {req, " boost"}, 64'(boost), mBoost);
    chk(64'(target) == mTarget, {req, " target"}, 64'(target), mTarget);
    chk(aboveEn == mAbove, {req, " aboveEn"}, 64'(aboveEn), 64'(mAbove));
    chk(belowEn == mBelow, {req, " belowEn"}, 64'(belowEn), 64'(mBelow));
  endtask

  task automatic fire(bit u, bit l);
    @(negedge clk);
    upEvt = u; lowEvt = l;
    @(negedge clk);
    upEvt = 1'b0; lowEvt = 1'b0;
  endtask

  task automatic waitDone(string req);
    bit seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    chk(seen, {req, " done seen"}, 64'(seen), 1);
    @(negedge clk);
    chk(!done, {req, " done single cycle"}, 64'(done), 0); // R9
  endtask

  task automatic quiet(int n, string req);
    int cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (done) cnt++;
    end
    chk(cnt == 0, {req, " no extra done"}, 64'(cnt), 0);
  endtask

  task automatic evt(bit up, string req);
    fire(up, !up);
    waitDone(req);
    modelEvt(up);
    checkOut(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    avgCount = 32'd3_000_000; maxFreq = 32'd800_000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    mTarget = 0;
    checkOut("R8 reset");
    chk(!done, "R8 reset done", 64'(done), 0);
    quiet(100, "R11 idle");

    // R1 R2 R7 directed upper events with the default coefficients
    evt(1'b1, "R1 up1");
    evt(1'b1, "R7 up2");
    maxFreq = 32'd100_000;
    evt(1'b1, "R2 up cap");
    chk(!aboveEn && belowEn, "R2 cap disarms upper", 64'({aboveEn, belowEn}), 1);

    // R3 R4 lower events down to the zero snap
    for (int i = 0; i < 5; i++) evt(1'b0, "R3 low");
    chk(boost == 0 && aboveEn && !belowEn, "R4 snap disarms lower",
        64'({boost == 0, aboveEn, belowEn}), 6);

    // R5 both strobes in one cycle
    fire(1'b1, 1'b1);
    waitDone("R5 both");
    modelEvt(1'b1);
    checkOut("R5 both");
    quiet(400, "R5 lower consumed");

    // R10 strobes during an update are kept and merged
    fire(1'b1, 1'b0);
    repeat (20) @(negedge clk);
    fire(1'b0, 1'b1);
    repeat (5) @(negedge clk);
    fire(1'b0, 1'b1);
    waitDone("R10 first");
    modelEvt(1'b1);
    checkOut("R10 first");
    waitDone("R10 pending");
    modelEvt(1'b0);
    checkOut("R10 pending");
    quiet(400, "R10 merged");

    // R6 saturated percentage products
    maxFreq = 32'hFFFF_FFFF; avgCount = 32'hFFFF_FFFF; periodMs = 9'd1; upThresh = 8'd1;
    upCoeff = 16'hFFFF;
    evt(1'b1, "R6 up");
    evt(1'b1, "R6 up sat");
    downCoeff = 16'd200;
    evt(1'b0, "R6 low sat");

    // R8 restart in the middle of an update
    fire(1'b1, 1'b0);
    repeat (30) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mBoost = 0; mTarget = 0; mAbove = 1'b1; mBelow = 1'b0;
    checkOut("R8 restart");
    quiet(400, "R8 update dropped");

    // random mix
    for (int n = 0; n < 40; n++) begin
      bit up;
      avgCount  = $urandom;
      periodMs  = 9'(($urandom % 256) + 1);
      upThresh  = 8'(($urandom % 100) + 1);
      upCoeff   = 16'($urandom % 1000);
      downCoeff = 16'($urandom % 120);
      maxFreq   = (n % 4 == 0) ? $urandom : 32'(($urandom % 2_000_000) + 1);
      up        = 1'($urandom % 2);
      evt(up, up ? "R1 random" : "R3 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule